// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between instruction commit and the data memory port of a core that follows total store ordering. A store that has cleared address translation can leave the head of the reorder buffer and be parked here. Younger instructions then commit without waiting for the write to finish. Parked stores are written to memory one at a time, oldest first, through a valid/ready drain port.

Loads are the only operations allowed to overtake parked stores. A load reads the buffer contents in the cycle it is presented and receives one of three verdicts:
- go to memory, when no parked store touches its bytes;
- take forwarded data, when the youngest parked store that touches its bytes covers every byte the load asks for;
- wait.

Two mechanisms restore strict ordering by waiting for the buffer to empty:
- a store-to-load fence request;
- an atomic read-modify-write, which counts as a store for ordering purposes.

Top module: `tso_store_queue`

## Requirements
- R1: A store is accepted on a cycle where `st_valid` and `st_ready` are both high. `st_ready` is high only when all of these hold: `st_xlat_ok` is high, the buffer holds fewer than DEPTH entries, and no fence is waiting on a non-empty buffer. A store offered with `st_xlat_ok` low is not accepted.
- R2: Accepted stores leave through the drain port in acceptance order. `dr_valid` is high exactly when the buffer is non-empty, and `dr_addr`/`dr_data`/`dr_be` show the oldest entry. That entry is removed only on a cycle with `dr_valid` and `dr_ready` both high; otherwise it stays in place unchanged.
- R3: With DEPTH entries held, `st_ready` is low and an offered store is dropped from consideration. The buffer never holds more than DEPTH entries.
- R4: A plain load with no overlapping buffered entry gets `ld_go` high in the same cycle with `ld_fwd` low, so it is served from memory even while older stores wait.
- R5: An entry overlaps a load when its address equals `ld_addr` and it shares at least one enabled byte with `ld_be`. If the youngest overlapping entry's byte enables include every bit set in `ld_be`, then `ld_go` and `ld_fwd` are high and `ld_fwd_data` is that entry's data word.
- R6: If the youngest overlapping entry does not cover every requested byte, `ld_go` stays low until that entry has drained.
- R7: While `fence_req` is high and the buffer is non-empty, `ld_go` and `st_ready` are low. `fence_done` is high exactly when `fence_req` is high and the buffer is empty. This includes the first cycle after the last drain, and a fence raised on an empty buffer completes at once.
- R8: A load flagged `ld_rmw` gets `ld_go` only while the buffer is empty, and never receives forwarded data.
- R9: After reset the buffer is empty: `dr_valid` is low and `st_ready` follows `st_xlat_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered from the reorder buffer head |
| st_xlat_ok | input | 1 | Offered store has passed translation and cannot fault |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data word |
| st_be | input | DW/8 | Store byte enables |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Load asking to graduate |
| ld_rmw | input | 1 | Load is the read half of an atomic read-modify-write |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Bytes the load needs |
| ld_go | output | 1 | Load may graduate this cycle |
| ld_fwd | output | 1 | Load takes `ld_fwd_data` instead of memory data |
| ld_fwd_data | output | DW | Forwarded data word |
| fence_req | input | 1 | Store-to-load fence waiting to complete |
| fence_done | output | 1 | Fence completes this cycle |
| dr_valid | output | 1 | Oldest entry offered to memory |
| dr_ready | input | 1 | Memory takes the offered entry |
| dr_addr | output | AW | Address of oldest entry |
| dr_data | output | DW | Data of oldest entry |
| dr_be | output | DW/8 | Byte enables of oldest entry |

## Verification
The bench builds a buffer holding two stores to one address with disjoint byte lanes. A design that forwarded from the oldest match, or ignored byte enables, would hand back the wrong word or forward partial data instead of waiting. It fills the buffer and offers one more store; a missing full check would overwrite the oldest entry, and the drain sequence would expose it. A fence is held across two drains: completing a cycle early, or letting a younger store slip in, would show on `fence_done` and `st_ready`. A read-modify-write that matches a buffered store must stay blocked, so a design that forwarded to it would graduate too soon.

// File: rtl/stq_pkg.sv
package stq_pkg;

  // Verdict of the forwarding search for one load
  typedef enum logic [1:0] {
    LDV_NONE = 2'd0,   // no buffered store touches the requested bytes
    LDV_FWD  = 2'd1,   // youngest toucher covers all requested bytes
    LDV_WAIT = 2'd2    // youngest toucher covers only part of them
  } ldv_e;

endpackage

// File: rtl/stq_ring.sv
module stq_ring #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BW    = DW / 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [BW-1:0] push_be_i,
  input  logic          pop_i,
  output logic [AW-1:0] slot_addr_o [DEPTH],
  output logic [DW-1:0] slot_data_o [DEPTH],
  output logic [BW-1:0] slot_be_o   [DEPTH],
  output logic [PW-1:0] head_o,
  output logic [CW-1:0] count_o
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] head_q, head_n, tail_q, tail_n;
  logic [CW-1:0] count_q, count_n;

  // next-state
  always_comb begin
    head_n  = head_q;
    tail_n  = tail_q;
    count_n = count_q;
    if (pop_i)  head_n = (head_q == LAST) ? '0 : head_q + 1'b1;
    if (push_i) tail_n = (tail_q == LAST) ? '0 : tail_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   count_n = count_q + CW'(1);
      2'b01:   count_n = count_q - CW'(1);
      default: count_n = count_q;
    endcase
  end

  // pointer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      count_q <= count_n;
    end
  end

  // entry storage, one enabled register set per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [BW-1:0] be_q;
    logic          wr_en;

    assign wr_en = push_i && (tail_q == PW'(g));

    always_ff @(posedge clk) begin
      if (wr_en) begin
        addr_q <= push_addr_i;
        data_q <= push_data_i;
        be_q   <= push_be_i;
      end
    end

    assign slot_addr_o[g] = addr_q;
    assign slot_data_o[g] = data_q;
    assign slot_be_o[g]   = be_q;
  end

  assign head_o  = head_q;
  assign count_o = count_q;

endmodule

// File: rtl/stq_fwd.sv
module stq_fwd
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BW    = DW / 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] slot_addr_i [DEPTH],
  input  logic [DW-1:0] slot_data_i [DEPTH],
  input  logic [BW-1:0] slot_be_i   [DEPTH],
  input  logic [PW-1:0] head_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [BW-1:0] ld_be_i,
  output ldv_e          verdict_o,
  output logic [DW-1:0] fwd_data_o
);

  logic [DEPTH-1:0] ovl;
  logic [DEPTH-1:0] cov;
  logic [DW-1:0]    age_data [DEPTH];

  // one lane per age position: age 0 is the oldest entry
  for (genvar a = 0; a < DEPTH; a++) begin : g_age
    logic [PW:0]   sum;
    logic [PW-1:0] idx;
    logic          live;
    logic [BW-1:0] common;

    assign sum    = {1'b0, head_i} + (PW+1)'(a);
    assign idx    = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
    assign live   = CW'(a) < count_i;
    assign common = slot_be_i[idx] & ld_be_i;
    assign ovl[a] = live && (slot_addr_i[idx] == ld_addr_i) && (|common);
    assign cov[a] = (common == ld_be_i);
    assign age_data[a] = slot_data_i[idx];
  end

  // the youngest overlapping entry decides
  always_comb begin
    verdict_o  = LDV_NONE;
    fwd_data_o = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (ovl[a]) begin
        verdict_o  = cov[a] ? LDV_FWD : LDV_WAIT;
        fwd_data_o = age_data[a];
      end
    end
  end

endmodule

// File: rtl/stq_gate.sv
module stq_gate
  import stq_pkg::*;
(
  input  logic ld_valid_i,
  input  logic ld_rmw_i,
  input  logic fence_req_i,
  input  logic empty_i,
  input  logic full_i,
  input  logic st_xlat_ok_i,
  input  ldv_e verdict_i,
  output logic ld_go_o,
  output logic ld_fwd_o,
  output logic st_ready_o,
  output logic fence_done_o
);

  logic fence_hold;
  logic ld_clear;

  always_comb begin
    fence_hold   = fence_req_i && !empty_i;
    ld_clear     = ld_rmw_i ? empty_i : (verdict_i != LDV_WAIT);
    ld_go_o      = ld_valid_i && !fence_hold && ld_clear;
    ld_fwd_o     = ld_go_o && !ld_rmw_i && (verdict_i == LDV_FWD);
    st_ready_o   = st_xlat_ok_i && !full_i && !fence_hold;
    fence_done_o = fence_req_i && empty_i;
  end

endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
  import stq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic            st_xlat_ok,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  output logic            st_ready,
  input  logic            ld_valid,
  input  logic            ld_rmw,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW/8-1:0] ld_be,
  output logic            ld_go,
  output logic            ld_fwd,
  output logic [DW-1:0]   ld_fwd_data,
  input  logic            fence_req,
  output logic            fence_done,
  output logic            dr_valid,
  input  logic            dr_ready,
  output logic [AW-1:0]   dr_addr,
  output logic [DW-1:0]   dr_data,
  output logic [DW/8-1:0] dr_be
);

  localparam int BW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [BW-1:0] slot_be   [DEPTH];
  logic [PW-1:0] head;
  logic [CW-1:0] count;
  logic          push, pop, empty, full;
  ldv_e          verdict;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign push  = st_valid && st_ready;
  assign pop   = dr_valid && dr_ready;

  stq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PW(PW), .CW(CW)) ring_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_addr_i (st_addr),
    .push_data_i (st_data),
    .push_be_i   (st_be),
    .pop_i       (pop),
    .slot_addr_o (slot_addr),
    .slot_data_o (slot_data),
    .slot_be_o   (slot_be),
    .head_o      (head),
    .count_o     (count)
  );

  stq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PW(PW), .CW(CW)) fwd_i (
    .slot_addr_i (slot_addr),
    .slot_data_i (slot_data),
    .slot_be_i   (slot_be),
    .head_i      (head),
    .count_i     (count),
    .ld_addr_i   (ld_addr),
    .ld_be_i     (ld_be),
    .verdict_o   (verdict),
    .fwd_data_o  (ld_fwd_data)
  );

  stq_gate gate_i (
    .ld_valid_i   (ld_valid),
    .ld_rmw_i     (ld_rmw),
    .fence_req_i  (fence_req),
    .empty_i      (empty),
    .full_i       (full),
    .st_xlat_ok_i (st_xlat_ok),
    .verdict_i    (verdict),
    .ld_go_o      (ld_go),
    .ld_fwd_o     (ld_fwd),
    .st_ready_o   (st_ready),
    .fence_done_o (fence_done)
  );

  // drain port shows the oldest entry
  assign dr_valid = !empty;
  assign dr_addr  = slot_addr[head];
  assign dr_data  = slot_data[head];
  assign dr_be    = slot_be[head];

endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_xlat_ok,
  input logic          st_ready,
  input logic          dr_valid,
  input logic          dr_ready,
  input logic [AW-1:0] dr_addr,
  input logic [DW-1:0] dr_data,
  input logic          ld_valid,
  input logic          ld_rmw,
  input logic          ld_go,
  input logic          ld_fwd,
  input logic          fence_req,
  input logic          fence_done
);

  localparam int CW = $clog2(DEPTH + 2);

  // independent occupancy model from the port handshakes
  logic [CW-1:0] occ_q, occ_n;

  always_comb begin
    occ_n = occ_q;
    if (st_valid && st_ready) occ_n = occ_n + CW'(1);
    if (dr_valid && dr_ready) occ_n = occ_n - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_n;
  end

  // R1: no acceptance before translation has cleared
  p_xlat_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> st_xlat_ok);

  // R2: stalled head stays put
  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data));

  // R2, R9: drain valid tracks the handshake occupancy
  p_valid_occ_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid == (occ_q != '0));

  // R3: never beyond capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q <= CW'(DEPTH)) && ((occ_q == CW'(DEPTH)) -> !st_ready));

  // R4: a graduation needs a load
  p_go_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go |-> ld_valid);

  // R5: forwarding only for a graduating load
  p_fwd_needs_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd |-> ld_go);

  // R7: fence holds loads and stores while stores remain
  p_fence_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && dr_valid |-> !ld_go && !st_ready && !fence_done);

  // R7: fence completes as soon as the buffer is empty
  p_fence_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && !dr_valid |-> fence_done);

  // R8: atomic load graduates only on an empty buffer, unforwarded
  p_rmw_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go && ld_rmw |-> !dr_valid && !ld_fwd);

endmodule

bind tso_store_queue stq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_xlat_ok (st_xlat_ok),
  .st_ready   (st_ready),
  .dr_valid   (dr_valid),
  .dr_ready   (dr_ready),
  .dr_addr    (dr_addr),
  .dr_data    (dr_data),
  .ld_valid   (ld_valid),
  .ld_rmw     (ld_rmw),
  .ld_go      (ld_go),
  .ld_fwd     (ld_fwd),
  .fence_req  (fence_req),
  .fence_done (fence_done)
);

// File: tb/tso_store_queue_tb_top.sv
module tso_store_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int DW    = 32;

  localparam logic [1:0] OP_PUSH  = 2'd0;
  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_DRAIN = 2'd2;

  // load verdict codes: 0 wait, 1 memory, 2 forwarded
  localparam logic [1:0] V_WAIT = 2'd0;
  localparam logic [1:0] V_MEM  = 2'd1;
  localparam logic [1:0] V_FWD  = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [1:0]  exp_v;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{OP_PUSH,  4'd1, 32'h100, 32'h1111_1111, 4'hF, V_MEM },  // R1 oldest, all lanes
    '{OP_PUSH,  4'd1, 32'h104, 32'h2222_2222, 4'h3, V_MEM },  // R1 low lanes
    '{OP_PUSH,  4'd1, 32'h100, 32'hAAAA_AAAA, 4'hC, V_MEM },  // R1 youngest, high lanes
    '{OP_LOAD,  4'd5, 32'h100, 32'hAAAA_AAAA, 4'hC, V_FWD },  // R5 youngest covers
    '{OP_LOAD,  4'd5, 32'h100, 32'h1111_1111, 4'h3, V_FWD },  // R5 skip disjoint youngest
    '{OP_LOAD,  4'd6, 32'h100, 32'h0,         4'hF, V_WAIT},  // R6 partial cover
    '{OP_LOAD,  4'd6, 32'h104, 32'h0,         4'hF, V_WAIT},  // R6 partial cover
    '{OP_LOAD,  4'd4, 32'h200, 32'h0,         4'hF, V_MEM },  // R4 bypass
    '{OP_LOAD,  4'd5, 32'h104, 32'h2222_2222, 4'h1, V_FWD },  // R5 subset
    '{OP_DRAIN, 4'd2, 32'h100, 32'h1111_1111, 4'hF, V_MEM },  // R2 oldest first
    '{OP_LOAD,  4'd4, 32'h100, 32'h0,         4'h3, V_MEM },  // R4 drained lanes
    '{OP_DRAIN, 4'd2, 32'h104, 32'h2222_2222, 4'h3, V_MEM },  // R2
    '{OP_LOAD,  4'd6, 32'h100, 32'h0,         4'hF, V_WAIT},  // R6 remaining partial
    '{OP_DRAIN, 4'd2, 32'h100, 32'hAAAA_AAAA, 4'hC, V_MEM },  // R2
    '{OP_LOAD,  4'd4, 32'h100, 32'h0,         4'hF, V_MEM }   // R4 empty
  };

  logic            clk;
  logic            rst_n;
  logic            st_valid, st_xlat_ok;
  logic [AW-1:0]   st_addr;
  logic [DW-1:0]   st_data;
  logic [DW/8-1:0] st_be;
  logic            st_ready;
  logic            ld_valid, ld_rmw;
  logic [AW-1:0]   ld_addr;
  logic [DW/8-1:0] ld_be;
  logic            ld_go, ld_fwd;
  logic [DW-1:0]   ld_fwd_data;
  logic            fence_req, fence_done;
  logic            dr_valid, dr_ready;
  logic [AW-1:0]   dr_addr;
  logic [DW-1:0]   dr_data;
  logic [DW/8-1:0] dr_be;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  tso_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_xlat_ok(st_xlat_ok), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_ready(st_ready),
    .ld_valid(ld_valid), .ld_rmw(ld_rmw), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_go(ld_go), .ld_fwd(ld_fwd), .ld_fwd_data(ld_fwd_data),
    .fence_req(fence_req), .fence_done(fence_done),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_be(dr_be)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic idle();
    st_valid = 0; st_xlat_ok = 0; st_addr = '0; st_data = '0; st_be = '0;
    ld_valid = 0; ld_rmw = 0; ld_addr = '0; ld_be = '0;
    fence_req = 0; dr_ready = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    idle();
    st_valid = 1; st_xlat_ok = 1; st_addr = a; st_data = d; st_be = b;
    #2 chk("R1 push ready", {31'd0, st_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    st_xlat_ok = 1;
    #2;
    chk("R9 reset dr_valid", {31'd0, dr_valid}, 32'd0);
    chk("R9 reset st_ready", {31'd0, st_ready}, 32'd1);
    chk("R9 reset fence_done", {31'd0, fence_done}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    idle();

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VEC[i].op)
        OP_PUSH: begin
          st_valid = 1; st_xlat_ok = 1;
          st_addr = VEC[i].addr; st_data = VEC[i].data; st_be = VEC[i].be;
          #2 chk($sformatf("R%0d vec %0d st_ready", VEC[i].req, i), {31'd0, st_ready}, 32'd1);
        end
        OP_LOAD: begin
          logic [1:0] v;
          ld_valid = 1; ld_addr = VEC[i].addr; ld_be = VEC[i].be;
          #2;
          v = ld_fwd ? V_FWD : (ld_go ? V_MEM : V_WAIT);
          chk($sformatf("R%0d vec %0d verdict", VEC[i].req, i), {30'd0, v}, {30'd0, VEC[i].exp_v});
          if (VEC[i].exp_v == V_FWD)
            chk($sformatf("R%0d vec %0d fwd data", VEC[i].req, i), ld_fwd_data, VEC[i].data);
        end
        default: begin
          dr_ready = 1;
          #2;
          chk($sformatf("R%0d vec %0d dr_valid", VEC[i].req, i), {31'd0, dr_valid}, 32'd1);
          chk($sformatf("R%0d vec %0d dr_addr", VEC[i].req, i), dr_addr, VEC[i].addr);
          chk($sformatf("R%0d vec %0d dr_data", VEC[i].req, i), dr_data, VEC[i].data);
        end
      endcase
    end

    // R1: untranslated store is refused and not stored
    @(negedge clk); idle();
    st_valid = 1; st_xlat_ok = 0; st_addr = 32'h700; st_data = 32'h7; st_be = 4'hF;
    #2 chk("R1 no xlat st_ready", {31'd0, st_ready}, 32'd0);
    @(negedge clk); idle();
    #2 chk("R1 no xlat not stored", {31'd0, dr_valid}, 32'd0);

    // R7: fence on empty buffer completes at once, load proceeds
    @(negedge clk); idle();
    fence_req = 1; ld_valid = 1; ld_addr = 32'h300; ld_be = 4'hF;
    #2;
    chk("R7 empty fence_done", {31'd0, fence_done}, 32'd1);
    chk("R7 empty fence ld_go", {31'd0, ld_go}, 32'd1);

    // R7: fence behind two stores
    push(32'h10, 32'hD1D1_D1D1, 4'hF);
    push(32'h14, 32'hD2D2_D2D2, 4'hF);
    @(negedge clk); idle();
    fence_req = 1; ld_valid = 1; ld_addr = 32'h40; ld_be = 4'hF;
    st_valid = 1; st_xlat_ok = 1; st_addr = 32'h44; st_data = 32'hBAD0_0000; st_be = 4'hF;
    dr_ready = 1;
    #2;
    chk("R7 busy fence_done", {31'd0, fence_done}, 32'd0);
    chk("R7 busy ld_go", {31'd0, ld_go}, 32'd0);
    chk("R7 busy st_ready", {31'd0, st_ready}, 32'd0);
    @(negedge clk);
    st_valid = 0;
    #2;
    chk("R7 one left fence_done", {31'd0, fence_done}, 32'd0);
    chk("R7 one left dr_addr", dr_addr, 32'h14);
    @(negedge clk);
    #2;
    chk("R7 drained fence_done", {31'd0, fence_done}, 32'd1);
    chk("R7 drained ld_go", {31'd0, ld_go}, 32'd1);
    chk("R7 held store not stored", {31'd0, dr_valid}, 32'd0);

    // R8: atomic load waits for the buffer to drain, no forwarding
    push(32'h50, 32'h5555_5555, 4'hF);
    @(negedge clk); idle();
    ld_valid = 1; ld_rmw = 1; ld_addr = 32'h50; ld_be = 4'hF;
    #2;
    chk("R8 rmw match ld_go", {31'd0, ld_go}, 32'd0);
    chk("R8 rmw match ld_fwd", {31'd0, ld_fwd}, 32'd0);
    @(negedge clk);
    ld_addr = 32'h60; dr_ready = 1;
    #2 chk("R8 rmw nomatch ld_go", {31'd0, ld_go}, 32'd0);
    @(negedge clk);
    dr_ready = 0;
    #2;
    chk("R8 rmw empty ld_go", {31'd0, ld_go}, 32'd1);
    chk("R8 rmw empty ld_fwd", {31'd0, ld_fwd}, 32'd0);

    // R3: fill to depth, overflow attempt, then drain in order
    for (int k = 0; k < DEPTH; k++)
      push(32'h1000 + 32'(4 * k), 32'hC000_0000 + 32'(k), 4'hF);
    @(negedge clk); idle();
    st_valid = 1; st_xlat_ok = 1; st_addr = 32'hDEA0; st_data = 32'hDEAD_BEEF; st_be = 4'hF;
    #2 chk("R3 full st_ready", {31'd0, st_ready}, 32'd0);
    @(negedge clk); idle();
    #2 chk("R2 stalled head addr", dr_addr, 32'h1000);
    @(negedge clk);
    #2 chk("R2 stalled head data", dr_data, 32'hC000_0000);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk); idle();
      dr_ready = 1;
      #2;
      chk("R2 order addr", dr_addr, 32'h1000 + 32'(4 * k));
      chk("R2 order data", dr_data, 32'hC000_0000 + 32'(k));
    end
    @(negedge clk); idle();
    #2 chk("R3 overflow store dropped", {31'd0, dr_valid}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule